// File: doc/BRIEF.md
# Comparator Change Interrupt with Reference Latches

This block turns changes on a set of comparator outputs into interrupt flags. Each channel keeps a reference copy of its comparator output. While the synchronised output differs from that copy, the channel's flag is forced to 1 on every clock. The reference copy is refreshed only when the processor touches the comparator status register, whether it reads it or writes it. An interrupt service routine therefore reads the status register first and then clears the flag. If it only clears the flag, the flag comes straight back.

The flags are sticky. Only software writing 0 clears them, and software writing 1 sets them to raise an interrupt on purpose. Flags are set whatever the enable bits hold. The interrupt request line combines the flags with a per-channel enable register, a peripheral-enable bit and a global-enable bit. A status access in the very cycle a new output value first reaches the compare loads that value into the reference, and that change then raises no flag.

The processor side is a single-cycle register bus with four word addresses: status, flags, channel enables and control. Reads return data combinationally.

Top module: `cmp_mismatch_irq`

## Requirements
- R1: Each comparator input passes through a synchroniser of SYNC_STAGES flops (default 2). The status register (address 0, bit c = channel c) shows an input change SYNC_STAGES clocks after the change, and the flag sets one clock later.
- R2: A channel's flag (address 1, bit c) becomes 1 whenever its synchronised output differs from its reference, even when every enable bit is 0. Other channels are unaffected.
- R3: While a mismatch persists, writing 0 to the flag leaves it reading 1, because the flag is set again on every clock.
- R4: Any read or write of the status register loads every reference with the current synchronised outputs. After that, writing 0 clears the flag and it stays 0.
- R5: Writing 1 to a flag bit sets that flag without any mismatch. Writing 0 with no mismatch clears it.
- R6: irq is 1 exactly when the global-enable bit (address 3, bit 1), the peripheral-enable bit (address 3, bit 0), and for some channel c both its flag and its enable (address 2, bit c) are 1.
- R7: If a status access happens in the cycle a new synchronised value first differs from the reference, the reference update wins and that change sets no flag.
- R8: Register bits above the defined fields read as 0. The status register is read-only.
- R9: During reset, all flags and enables clear and the references load from the synchronised inputs. Steady inputs therefore raise no flag after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_in | input | NCH | Asynchronous comparator outputs |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_sel is high |
| irq | output | 1 | Interrupt request |

## Verification
A reference latch that misses a refresh shows up as a flag that returns one clock after it is cleared. A reference that updates when it should not shows up as a change that never raises a flag. Both are visible on the flag register within a single bus access. A flag register with the wrong priority between write, set and reference refresh appears in the same-cycle corner case: the flag read straight after the status access reports it. Errors in the enable gating reach irq in the cycle after the register write, and an exhaustive sweep over the flag and enable values exposes them.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
   typedef enum logic [1:0] {
      REG_STATUS = 2'd0,
      REG_FLAGS  = 2'd1,
      REG_ENABLE = 2'd2,
      REG_CTRL   = 2'd3
   } cmi_reg_e;

   localparam int CTRL_PERIPH_BIT = 0;
   localparam int CTRL_GLOBAL_BIT = 1;
   localparam int CTRL_BITS       = 2;
endpackage

// File: rtl/cmi_sync.sv
module cmi_sync #(
   parameter int NCH    = 2,
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic [NCH-1:0] async_in,
   output logic [NCH-1:0] sync_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("cmi_sync: STAGES must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [STAGES-1:0] chain;
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) chain <= async_in[c];
      end else begin : g_multi
         always_ff @(posedge clk) chain <= {chain[STAGES-2:0], async_in[c]};
      end
      assign sync_out[c] = chain[STAGES-1];
   end
endmodule

// File: rtl/cmi_ref_track.sv
module cmi_ref_track #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] cur,
   input  logic           load,
   output logic [NCH-1:0] ref_q,
   output logic [NCH-1:0] diff
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n || load) ref_q[c] <= cur[c];
      end
      assign diff[c] = rst_n & (cur[c] ^ ref_q[c]);
   end
endmodule

// File: rtl/cmi_flag_bank.sv
module cmi_flag_bank #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] diff,
   input  logic           suppress,
   input  logic           wr_en,
   input  logic [NCH-1:0] wr_val,
   output logic [NCH-1:0] flags
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic base;
      assign base = wr_en ? wr_val[c] : flags[c];
      always_ff @(posedge clk) begin
         if (!rst_n) flags[c] <= 1'b0;
         else        flags[c] <= base | (diff[c] & ~suppress);
      end
   end
endmodule

// File: rtl/cmi_regif.sv
module cmi_regif
   import cmi_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NCH-1:0]    status,
   input  logic [NCH-1:0]    flags,
   output logic              stat_touch,
   output logic              flag_wr,
   output logic [NCH-1:0]    flag_wval,
   output logic [NCH-1:0]    en_q,
   output logic              pen_q,
   output logic              gen_q
);
   logic     upper_ok;
   logic     hit;
   cmi_reg_e sel_reg;

   if (ADDR_W > 2) begin : g_wide_addr
      assign upper_ok = ~|bus_addr[ADDR_W-1:2];
   end else begin : g_narrow_addr
      assign upper_ok = 1'b1;
   end

   assign hit        = bus_sel & upper_ok;
   assign sel_reg    = cmi_reg_e'(bus_addr[1:0]);
   assign stat_touch = hit && (sel_reg == REG_STATUS);
   assign flag_wr    = hit && bus_wr && (sel_reg == REG_FLAGS);
   assign flag_wval  = bus_wdata[NCH-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         pen_q <= 1'b0;
         gen_q <= 1'b0;
      end else if (hit && bus_wr) begin
         if (sel_reg == REG_ENABLE) en_q <= bus_wdata[NCH-1:0];
         if (sel_reg == REG_CTRL) begin
            pen_q <= bus_wdata[CTRL_PERIPH_BIT];
            gen_q <= bus_wdata[CTRL_GLOBAL_BIT];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (upper_ok) begin
         unique case (sel_reg)
            REG_STATUS: bus_rdata[NCH-1:0] = status;
            REG_FLAGS:  bus_rdata[NCH-1:0] = flags;
            REG_ENABLE: bus_rdata[NCH-1:0] = en_q;
            REG_CTRL: begin
               bus_rdata[CTRL_PERIPH_BIT] = pen_q;
               bus_rdata[CTRL_GLOBAL_BIT] = gen_q;
            end
         endcase
      end
   end
endmodule

// File: rtl/cmp_mismatch_irq.sv
module cmp_mismatch_irq
   import cmi_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    cmp_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   if (NCH < 1 || NCH > DATA_W) begin : g_bad_nch
      $error("cmp_mismatch_irq: NCH must lie in 1..DATA_W");
   end
   if (DATA_W < CTRL_BITS) begin : g_bad_dw
      $error("cmp_mismatch_irq: DATA_W too narrow for control bits");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("cmp_mismatch_irq: ADDR_W must be at least 2");
   end

   logic [NCH-1:0] sync_q;
   logic [NCH-1:0] ref_q;
   logic [NCH-1:0] diff;
   logic [NCH-1:0] flags;
   logic [NCH-1:0] en_q;
   logic [NCH-1:0] flag_wval;
   logic           pen_q;
   logic           gen_q;
   logic           stat_touch;
   logic           flag_wr;

   cmi_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .async_in (cmp_in),
      .sync_out (sync_q)
   );

   cmi_ref_track #(.NCH(NCH)) i_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (sync_q),
      .load  (stat_touch),
      .ref_q (ref_q),
      .diff  (diff)
   );

   cmi_flag_bank #(.NCH(NCH)) i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .diff     (diff),
      .suppress (stat_touch),
      .wr_en    (flag_wr),
      .wr_val   (flag_wval),
      .flags    (flags)
   );

   cmi_regif #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .status     (sync_q),
      .flags      (flags),
      .stat_touch (stat_touch),
      .flag_wr    (flag_wr),
      .flag_wval  (flag_wval),
      .en_q       (en_q),
      .pen_q      (pen_q),
      .gen_q      (gen_q)
   );

   assign irq = gen_q & pen_q & (|(flags & en_q));
endmodule

// File: rtl/cmi_checker.sv
module cmi_checker #(
   parameter int NCH    = 2,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [NCH-1:0]    sync_q,
   input logic [NCH-1:0]    ref_q,
   input logic [NCH-1:0]    diff,
   input logic [NCH-1:0]    flags,
   input logic [NCH-1:0]    en_q,
   input logic              pen_q,
   input logic              gen_q,
   input logic              stat_touch,
   input logic              flag_wr,
   input logic [NCH-1:0]    flag_wval
);
   localparam int PAD_LSB = (NCH > 2) ? NCH : 2;

   // R2
   mismatch_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|diff) && !stat_touch) |=> ((flags & $past(diff)) == $past(diff)));

   // R4
   ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_touch |=> (ref_q == $past(sync_q)));

   // R4
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_touch |=> $stable(ref_q));

   // R7
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_touch && (flags == '0)) |=> (flags == '0));

   // R5
   flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && !(|diff)) |=> (flags == $past(flag_wval)));

   // R6
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (gen_q && pen_q && (|(flags & en_q))));

   // R8
   rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |-> (bus_rdata[DATA_W-1:PAD_LSB] == '0));
endmodule

bind cmp_mismatch_irq cmi_checker #(.NCH(NCH), .DATA_W(DATA_W)) i_cmi_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_rdata  (bus_rdata),
   .irq        (irq),
   .sync_q     (sync_q),
   .ref_q      (ref_q),
   .diff       (diff),
   .flags      (flags),
   .en_q       (en_q),
   .pen_q      (pen_q),
   .gen_q      (gen_q),
   .stat_touch (stat_touch),
   .flag_wr    (flag_wr),
   .flag_wval  (flag_wval)
);

// File: tb/test_cmp_mismatch_irq.sv
module test_cmp_mismatch_irq;
   localparam int NCH = 2;
   localparam int DW  = 8;
   localparam int AW  = 2;
   localparam logic [AW-1:0] A_STAT = 2'd0, A_FLAG = 2'd1, A_EN = 2'd2, A_CTRL = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NCH-1:0] cmp_in = 2'b10;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cmp_mismatch_irq #(.NCH(NCH), .SYNC_STAGES(2), .DATA_W(DW), .ADDR_W(AW)) i_cmp_mismatch_irq (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   // tasks are entered just after a falling edge
   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 irq after reset", int'(irq), 0);
      bus_read(A_FLAG, rd); chk("R9 flags after reset", int'(rd), 0);
      bus_read(A_EN, rd);   chk("R9 enables after reset", int'(rd), 0);
      bus_read(A_CTRL, rd); chk("R9 ctrl after reset", int'(rd), 0);
      repeat (3) @(negedge clk);
      bus_read(A_FLAG, rd); chk("R9 no flag with steady inputs", int'(rd), 0);
      bus_read(A_STAT, rd); chk("R9 status shows inputs", int'(rd), 2);

      // R1 latency and R2 single-channel set with enables clear
      cmp_in = 2'b11;
      @(negedge clk); @(negedge clk);
      bus_read(A_FLAG, rd); chk("R1 flag not yet set", int'(rd), 0);
      bus_read(A_FLAG, rd); chk("R1 R2 flag for channel 0 only", int'(rd), 1);
      chk("R2 irq low with enables clear", int'(irq), 0);

      // R3 clearing without status access does not stick
      bus_write(A_FLAG, 8'h00);
      bus_read(A_FLAG, rd); chk("R3 flag re-set after clear", int'(rd), 1);
      repeat (3) @(negedge clk);
      bus_write(A_FLAG, 8'h00);
      bus_read(A_FLAG, rd); chk("R3 flag still re-set", int'(rd), 1);

      // R4 status read ends mismatch
      bus_read(A_STAT, rd); chk("R4 status value", int'(rd), 3);
      bus_write(A_FLAG, 8'h00);
      repeat (4) @(negedge clk);
      bus_read(A_FLAG, rd); chk("R4 flag stays clear after read", int'(rd), 0);

      // R4 status write also refreshes; R8 status is read-only
      cmp_in = 2'b01;
      repeat (4) @(negedge clk);
      bus_read(A_FLAG, rd); chk("R2 channel 1 flag", int'(rd), 2);
      bus_write(A_STAT, 8'hFF);
      bus_write(A_FLAG, 8'h00);
      repeat (3) @(negedge clk);
      bus_read(A_FLAG, rd); chk("R4 flag clear after status write", int'(rd), 0);
      bus_read(A_STAT, rd); chk("R8 status unaffected by write", int'(rd), 1);

      // R5 simulated interrupt
      bus_write(A_FLAG, 8'h02);
      bus_read(A_FLAG, rd); chk("R5 write 1 sets flag", int'(rd), 2);
      bus_write(A_FLAG, 8'h00);
      bus_read(A_FLAG, rd); chk("R5 write 0 clears flag", int'(rd), 0);

      // R8 unused bits read 0
      bus_write(A_FLAG, 8'hFF); bus_read(A_FLAG, rd); chk("R8 flag pad", int'(rd), 3);
      bus_write(A_EN, 8'hFF);   bus_read(A_EN, rd);   chk("R8 enable pad", int'(rd), 3);
      bus_write(A_CTRL, 8'hFF); bus_read(A_CTRL, rd); chk("R8 ctrl pad", int'(rd), 3);

      // R6 exhaustive gating sweep
      for (int v = 0; v < 64; v++) begin
         int f, e, pe, ge, exp;
         f = v & 3; e = (v >> 2) & 3; pe = (v >> 4) & 1; ge = (v >> 5) & 1;
         bus_write(A_FLAG, 8'(f));
         bus_write(A_EN, 8'(e));
         bus_write(A_CTRL, 8'((ge << 1) | pe));
         exp = ((f & e) != 0 && pe == 1 && ge == 1) ? 1 : 0;
         chk($sformatf("R6 irq f=%0d e=%0d p=%0d g=%0d", f, e, pe, ge), int'(irq), exp);
      end
      bus_write(A_CTRL, 8'h00);
      bus_write(A_EN, 8'h00);
      bus_write(A_FLAG, 8'h00);

      // R7 status access one cycle early: change still flags
      cmp_in = 2'b00;
      @(negedge clk);
      bus_read(A_STAT, rd);
      @(negedge clk);
      bus_read(A_FLAG, rd); chk("R7 early access, flag set", int'(rd), 1);
      bus_read(A_STAT, rd);
      bus_write(A_FLAG, 8'h00);

      // R7 status access in the cycle the change arrives: flag lost
      cmp_in = 2'b10;
      @(negedge clk); @(negedge clk);
      bus_read(A_STAT, rd); chk("R7 status shows new value", int'(rd), 2);
      repeat (2) @(negedge clk);
      bus_read(A_FLAG, rd); chk("R7 same-cycle change lost", int'(rd), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule